// File: doc/BRIEF.md
# Sixteen-Bit Timer/Event Counter with Capture, Reload and Baud Tick

This block is a 16-bit up-counter held as a low and a high byte. It counts either machine cycles, where one machine cycle lasts a fixed number of clock periods (twelve by default), or falling edges seen on an external event pin. A control register starts and stops it and picks what happens at the top of the count. In reload operation, wrapping past all-ones loads a programmable 16-bit reload value and raises a sticky overflow flag. In capture operation the counter wraps freely to zero, and a falling edge on a separate capture pin copies the running count into a capture register. In baud operation each wrap reloads the counter and emits a one-clock tick for a serial port, and the flag is left alone.

Both pins are sampled once per machine cycle. An edge counts only when one sample is high and the next one is low. The resulting action takes effect at the following machine cycle, so the fastest edge rate that can be recognised is one per two machine cycles. Software reaches every register through a plain byte-wide write port and a combinational read port.

Top module: `tc16_timer`

## Requirements
- R1: While reset is high and after it is released, every readable register (addresses 0 to 6) reads zero, and `baud_tick` and `ovf_flag` are low.
- R2: With the control register at run=1 (bit 0) and event select=0 (bit 1), the count goes up by one once every PRESCALE clocks. The machine-cycle boundary falls on the clock edge after the internal divider has spent PRESCALE-1 clocks since reset or since the previous boundary.
- R3: With run=1 and event select=1, the count goes up by one only at the machine cycle after the one where a low sample of `evt_pin` followed a high sample at the previous machine cycle. A pulse that falls between two samples is not counted.
- R4: With run=0 the count holds its value whatever the pins do.
- R5: In reload operation (run=1, bits 3 and 4 both 0, bit 2 = 0), an increment from 0xFFFF loads the reload register (address 3 low byte, address 4 high byte) and sets the overflow flag (control bit 7).
- R6: In capture operation (run=1, bits 3 and 4 both 0, bit 2 = 1), an increment from 0xFFFF gives zero and sets the flag. A falling edge on `cap_pin`, detected by the same two-sample rule, copies the current count into the capture register (address 5 low, address 6 high) at the next machine cycle.
- R7: When run=1 and either baud bit (3 or 4) is set, baud operation wins over bit 2. An increment from 0xFFFF loads the reload value and raises `baud_tick` for exactly one clock, and the flag is unchanged.
- R8: The overflow flag stays set until a write to address 0 with bit 7 = 0. A write with bit 7 = 1 neither sets nor clears it, and an overflow in the same cycle as a clearing write leaves it set.
- R9: A write to address 1 (count low byte) or address 2 (count high byte) replaces that byte. It suppresses any increment, reload or flag change in that clock.
- R10: Address 0 reads back run, event select, capture select, receive-baud and transmit-baud in bits 0 to 4 and the flag in bit 7, with bits 5 and 6 at zero. The reload register reads back what was written to it, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| evt_pin | input | 1 | External event input, counted on falling edges |
| cap_pin | input | 1 | Capture trigger input, acts on falling edges |
| baud_tick | output | 1 | One-clock pulse per wrap in baud operation |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with a machine cycle of three clocks instead of twelve and keeps the default byte width. This lets a preloaded count near 0xFFFF reach its wrap, reload, capture and baud tick within a few hundred clocks. The short machine cycle also lets pin toggles of one, two and three clocks fall on either side of a sample, which exercises both missed pulses and back-to-back edge pairs. A behavioural model tracks every register and both outputs and is compared on every clock while the read address rotates through the whole map.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_RLD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CAP_LO = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_CAP_HI = 3'd6;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_RELOAD  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_BAUD    = 2'd3
    } tc_mode_e;

    typedef struct packed {
        logic flag;
        logic tx_baud;
        logic rx_baud;
        logic cap_sel;
        logic evt_sel;
        logic run;
    } tc_ctrl_t;

    // Priority: stopped, then baud, then capture/reload select.
    function automatic tc_mode_e pick_mode(tc_ctrl_t c);
        if (!c.run)                    return MODE_OFF;
        else if (c.rx_baud || c.tx_baud) return MODE_BAUD;
        else if (c.cap_sel)            return MODE_CAPTURE;
        else                           return MODE_RELOAD;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(tc_ctrl_t c);
        return {c.flag, 2'b00, c.tx_baud, c.rx_baud, c.cap_sel, c.evt_sel, c.run};
    endfunction

endpackage

// File: rtl/tc16_prescaler.sv
module tc16_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tc16_fall_detect.sv
module tc16_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fire
);
    logic sample_q;
    logic pend_q;

    // Acts one machine cycle after a high-then-low pair of samples.
    assign fire = pend_q && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (tick) begin
            pend_q   <= sample_q && !pin;
            sample_q <= pin;
        end
    end
endmodule

// File: rtl/tc16_core.sv
module tc16_core
    import tc16_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                evt_fire,
    input  logic                cap_fire,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [2*HALF_W-1:0] cnt_o,
    output logic [2*HALF_W-1:0] rld_o,
    output logic [2*HALF_W-1:0] cap_o,
    output tc_ctrl_t            ctrl_o,
    output tc_mode_e            mode_o,
    output logic                baud_tick_o
);
    localparam int CW = 2 * HALF_W;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] rld_q, rld_d;
    logic [CW-1:0] cap_q, cap_d;
    tc_ctrl_t      ctrl_q, ctrl_d;
    logic          btick_q, btick_d;
    tc_mode_e      mode;
    logic          inc_en;
    logic          at_top;
    logic          cnt_wr;
    logic          ctrl_wr;
    logic          flag_set;

    assign mode    = pick_mode(ctrl_q);
    assign at_top  = &cnt_q;
    assign inc_en  = (mode != MODE_OFF) && (ctrl_q.evt_sel ? evt_fire : tick);
    assign cnt_wr  = wr_en && (wr_addr == ADDR_CNT_LO || wr_addr == ADDR_CNT_HI);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_comb begin
        cnt_d    = cnt_q;
        rld_d    = rld_q;
        cap_d    = cap_q;
        ctrl_d   = ctrl_q;
        btick_d  = 1'b0;
        flag_set = 1'b0;

        if (cnt_wr) begin
            for (int h = 0; h < 2; h++) begin
                if (wr_addr == ADDR_CNT_LO + ADDR_W'(h))
                    cnt_d[h*HALF_W +: HALF_W] = wr_data;
            end
        end else if (inc_en) begin
            if (at_top) begin
                if (mode == MODE_CAPTURE) cnt_d = '0;
                else                      cnt_d = rld_q;
                if (mode == MODE_BAUD)    btick_d  = 1'b1;
                else                      flag_set = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        if (cap_fire && mode == MODE_CAPTURE)
            cap_d = cnt_q;

        if (wr_en) begin
            for (int h = 0; h < 2; h++) begin
                if (wr_addr == ADDR_RLD_LO + ADDR_W'(h))
                    rld_d[h*HALF_W +: HALF_W] = wr_data;
            end
        end

        if (ctrl_wr) begin
            ctrl_d.run     = wr_data[0];
            ctrl_d.evt_sel = wr_data[1];
            ctrl_d.cap_sel = wr_data[2];
            ctrl_d.rx_baud = wr_data[3];
            ctrl_d.tx_baud = wr_data[4];
        end

        if (flag_set)                    ctrl_d.flag = 1'b1;
        else if (ctrl_wr && !wr_data[7]) ctrl_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            cap_q   <= '0;
            ctrl_q  <= '0;
            btick_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            rld_q   <= rld_d;
            cap_q   <= cap_d;
            ctrl_q  <= ctrl_d;
            btick_q <= btick_d;
        end
    end

    assign cnt_o       = cnt_q;
    assign rld_o       = rld_q;
    assign cap_o       = cap_q;
    assign ctrl_o      = ctrl_q;
    assign mode_o      = mode;
    assign baud_tick_o = btick_q;
endmodule

// File: rtl/tc16_timer.sv
module tc16_timer
    import tc16_pkg::*;
#(
    parameter int PRESCALE = 12,
    parameter int HALF_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data,
    input  logic              evt_pin,
    input  logic              cap_pin,
    output logic              baud_tick,
    output logic              ovf_flag
);
    localparam int CW = 2 * HALF_W;

    logic          mc_tick;
    logic [1:0]    pins;
    logic [1:0]    fires;
    logic [CW-1:0] cnt_w, rld_w, cap_w;
    tc_ctrl_t      ctrl_w;
    tc_mode_e      mode_w;

    assign pins = {cap_pin, evt_pin};

    tc16_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (mc_tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_edge
        tc16_fall_detect u_fd (
            .clk  (clk),
            .rst  (rst),
            .tick (mc_tick),
            .pin  (pins[g]),
            .fire (fires[g])
        );
    end

    tc16_core #(.HALF_W(HALF_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick        (mc_tick),
        .evt_fire    (fires[0]),
        .cap_fire    (fires[1]),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cnt_o       (cnt_w),
        .rld_o       (rld_w),
        .cap_o       (cap_w),
        .ctrl_o      (ctrl_w),
        .mode_o      (mode_w),
        .baud_tick_o (baud_tick)
    );

    assign ovf_flag = ctrl_w.flag;

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = HALF_W'(ctrl_to_byte(ctrl_w));
            ADDR_CNT_LO: rd_data = cnt_w[HALF_W-1:0];
            ADDR_CNT_HI: rd_data = cnt_w[CW-1:HALF_W];
            ADDR_RLD_LO: rd_data = rld_w[HALF_W-1:0];
            ADDR_RLD_HI: rd_data = rld_w[CW-1:HALF_W];
            ADDR_CAP_LO: rd_data = cap_w[HALF_W-1:0];
            ADDR_CAP_HI: rd_data = cap_w[CW-1:HALF_W];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tc16_sva.sv
module tc16_sva
    import tc16_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [HALF_W-1:0]   wr_data,
    input tc_mode_e            mode,
    input logic [2*HALF_W-1:0] cnt,
    input logic [2*HALF_W-1:0] rld,
    input logic                baud_tick,
    input logic                ovf_flag
);
    AST_BAUD_NEEDS_BAUD_MODE: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(mode) == MODE_BAUD); // R7

    AST_BAUD_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick); // R7

    AST_FLAG_NEVER_FROM_BAUD: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(mode) != MODE_BAUD); // R7

    AST_FLAG_CLEARS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(wr_en && wr_addr == ADDR_CTRL && !wr_data[7])); // R8

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF && !wr_en) |=> $stable(cnt)); // R4

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovf_flag) && $past(mode) == MODE_RELOAD) |-> cnt == $past(rld)); // R5
endmodule

bind tc16_timer tc16_sva #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode      (mode_w),
    .cnt       (cnt_w),
    .rld       (rld_w),
    .baud_tick (baud_tick),
    .ovf_flag  (ovf_flag)
);

// File: tb/tc16_timer_tb.sv
module tc16_timer_tb;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       evt_pin = 1'b0;
    logic       cap_pin = 1'b0;
    logic       baud_tick;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference state
    int m_pc = 0;
    bit m_se = 0, m_pe = 0, m_sc = 0, m_pcp = 0;
    int m_cnt = 0, m_rld = 0, m_cap = 0;
    bit m_run = 0, m_sel = 0, m_capm = 0, m_rx = 0, m_tx = 0, m_flag = 0, m_bt = 0;

    always #2.5 clk = ~clk;

    tc16_timer #(.PRESCALE(P), .HALF_W(8)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_pin(evt_pin), .cap_pin(cap_pin),
        .baud_tick(baud_tick), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        bit tk, fe, fc, inc, setf, nbt;
        int mode, ncnt, ncap;
        if (rst) begin
            m_pc = 0; m_se = 0; m_pe = 0; m_sc = 0; m_pcp = 0;
            m_cnt = 0; m_rld = 0; m_cap = 0;
            m_run = 0; m_sel = 0; m_capm = 0; m_rx = 0; m_tx = 0; m_flag = 0; m_bt = 0;
        end else begin
            tk = (m_pc == P - 1);
            fe = m_pe && tk;
            fc = m_pcp && tk;
            mode = !m_run ? 0 : (m_rx || m_tx) ? 3 : m_capm ? 2 : 1;
            inc = (mode != 0) && (m_sel ? fe : tk);
            setf = 0; nbt = 0; ncnt = m_cnt; ncap = m_cap;
            if (wr_en && wr_addr == 1)      ncnt = (m_cnt & 32'hFF00) | wr_data;
            else if (wr_en && wr_addr == 2) ncnt = (m_cnt & 32'h00FF) | (int'(wr_data) << 8);
            else if (inc) begin
                if (m_cnt == 32'hFFFF) begin
                    ncnt = (mode == 2) ? 0 : m_rld;
                    if (mode == 3) nbt = 1; else setf = 1;
                end else ncnt = m_cnt + 1;
            end
            if (fc && mode == 2) ncap = m_cnt;
            if (wr_en && wr_addr == 3) m_rld = (m_rld & 32'hFF00) | wr_data;
            if (wr_en && wr_addr == 4) m_rld = (m_rld & 32'h00FF) | (int'(wr_data) << 8);
            if (wr_en && wr_addr == 0) begin
                m_run = wr_data[0]; m_sel = wr_data[1]; m_capm = wr_data[2];
                m_rx = wr_data[3]; m_tx = wr_data[4];
            end
            if (setf) m_flag = 1;
            else if (wr_en && wr_addr == 0 && !wr_data[7]) m_flag = 0;
            m_cnt = ncnt; m_cap = ncap; m_bt = nbt;
            if (tk) begin
                m_pe = m_se && !evt_pin; m_se = evt_pin;
                m_pcp = m_sc && !cap_pin; m_sc = cap_pin;
            end
            m_pc = tk ? 0 : m_pc + 1;
        end
    end

    function automatic int model_read(int a);
        case (a)
            0: return {m_flag, 2'b00, m_tx, m_rx, m_capm, m_sel, m_run};
            1: return m_cnt & 8'hFF;
            2: return (m_cnt >> 8) & 8'hFF;
            3: return m_rld & 8'hFF;
            4: return (m_rld >> 8) & 8'hFF;
            5: return m_cap & 8'hFF;
            6: return (m_cap >> 8) & 8'hFF;
            default: return 0;
        endcase
    endfunction

    task automatic check(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", t, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cycles++;
        check(tag, $sformatf("rd[%0d]", rd_addr), int'(rd_data), model_read(int'(rd_addr)));
        check(tag, "ovf_flag", int'(ovf_flag), int'(m_flag));
        check("R7", "baud_tick", int'(baud_tick), int'(m_bt));
        rd_addr = (rd_addr == 3'd7) ? 3'd0 : rd_addr + 3'd1;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // evt_pin toggles every k clocks for n clocks
    task automatic toggle_evt(int k, int n);
        for (int i = 0; i < n; i++) begin
            if (i % k == 0) evt_pin = ~evt_pin;
            cyc();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #0.1;
            check("R1", "reset read", int'(rd_data), 0);
        end
        check("R1", "reset baud_tick", int'(baud_tick), 0);
        check("R1", "reset flag", int'(ovf_flag), 0);
        rst = 1'b0;
        tag = "R1"; run_n(8);

        tag = "R10";
        wr(3, 8'h34); wr(4, 8'h12); wr(0, 8'h06); run_n(8); wr(0, 8'h00); run_n(8);

        tag = "R2";
        wr(1, 8'hF0); wr(2, 8'hFF); wr(0, 8'h01); run_n(30);
        tag = "R5"; run_n(40);
        tag = "R8"; wr(0, 8'h81); run_n(6); wr(0, 8'h01); run_n(6);

        tag = "R3"; wr(0, 8'h03);
        toggle_evt(3, 60); toggle_evt(1, 20); toggle_evt(2, 30); toggle_evt(5, 50); toggle_evt(7, 60);
        tag = "R4"; wr(0, 8'h02); toggle_evt(2, 40);

        tag = "R6"; wr(1, 8'hC0); wr(2, 8'hFF); wr(0, 8'h05);
        for (int i = 0; i < 300; i++) begin
            if (i % 11 == 0) cap_pin = ~cap_pin;
            cyc();
        end
        tag = "R8"; wr(0, 8'h05); run_n(5);

        tag = "R7"; wr(3, 8'hF8); wr(4, 8'hFF); wr(1, 8'hF0); wr(2, 8'hFF);
        wr(0, 8'h0D); run_n(100);
        wr(0, 8'h13); toggle_evt(2, 120);

        tag = "R9"; wr(0, 8'h01);
        for (int i = 0; i < 20; i++) begin
            wr(1 + (i % 2), 8'hFD + i); run_n(i % 4);
        end
        wr(1, 8'hFE); wr(2, 8'hFF); run_n(2); wr(1, 8'h10); run_n(6);

        tag = "R3"; wr(0, 8'h0B);
        for (int i = 0; i < 400; i++) begin
            evt_pin = 1'($urandom_range(0, 1));
            cap_pin = 1'($urandom_range(0, 1));
            cyc();
        end
        tag = "R6"; wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h07);
        for (int i = 0; i < 300; i++) begin
            evt_pin = 1'($urandom_range(0, 1));
            cap_pin = 1'($urandom_range(0, 1));
            cyc();
        end
        tag = "R10"; run_n(16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule